// File: doc/BRIEF.md
# Scratchpad-Verified Memory Controller

This block is the memory command layer of a single-wire slave that sits behind the ROM-selection logic. It handles one bit at a time. The master writes a bit with a one-cycle `slot_wr` strobe. It reads a bit by sampling `tx_bit` and then strobing `slot_rd`, which moves to the next bit. `line_reset` marks the end of a transaction. After it, the next eight written bits form a fresh command byte. All bytes travel least significant bit first.

Writes never go straight to main memory. The master first fills a 32-byte staging buffer and reads it back together with a status byte. That status byte holds the ending offset plus flags for overflow, partial byte and authorization accepted. The master then commits the data with a copy command, echoing the two address bytes and the status byte exactly. Main memory is a synchronous array of `PAGES` pages of 32 bytes. A copy keeps `copy_busy` high for `COPY_CYCLES` clock cycles, which stands for the copy time in the application.

Top module: `scratch_mem_ctrl`

## Requirements
- R1: The first byte after a line reset selects the operation: 0Fh write staging buffer, AAh read staging buffer, 55h copy, F0h read memory. Any other code makes `tx_bit` read as 1 until the next line reset, and further written bytes are not taken as commands. Bytes are sent and received bit 0 first.
- R2: Write staging buffer takes the low address byte and then the high address byte. It then clears the three flags and stores data bytes from buffer offset = address bits 4:0. The ending offset (status bits 4:0) becomes the offset of the last byte touched. Writing two bytes at address 0026h gives a status of 07h.
- R3: Once the byte at offset 1Fh is complete, any further bit sets the overflow flag (status bit 6). That bit is not stored.
- R4: If the number of data bits is not a multiple of 8, the partial flag (status bit 5) is set. The trailing bits are stored in the low positions of their byte, with the other positions zero.
- R5: Read staging buffer returns the low address byte, the high address byte and the status byte. It then returns buffer bytes from offset address[4:0] through offset 1Fh, and FFh after that.
- R6: If the three bytes after 55h equal the low address, the high address and the status, in that order, the authorization flag (status bit 7) is set. Buffer bytes from the start offset through the ending offset are then written to memory at {address[15:5], offset}, and `copy_busy` stays high for `COPY_CYCLES` cycles. After that, `tx_bit` reads 0 until a line reset.
- R7: If any of the three authorization bytes differs, nothing is written, the authorization flag stays clear, and `tx_bit` reads 1 until a line reset.
- R8: A line reset that arrives while `copy_busy` is high has no effect.
- R9: Read memory loads both address bytes into the address registers. It then returns memory bytes from that address with auto-increment through address PAGES*32-1, and FFh beyond that. The status byte is unchanged.
- R10: Only a write staging buffer command clears the authorization flag. It survives read memory and read staging buffer.
- R11: After `rst`, `tx_bit` is 1, `copy_busy` is 0, and both address bytes and the status byte are 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_reset | input | 1 | One-cycle strobe: master issued a bus reset |
| slot_wr | input | 1 | One-cycle strobe: master writes a bit |
| slot_data | input | 1 | Bit value written with `slot_wr` |
| slot_rd | input | 1 | One-cycle strobe: master consumed the current `tx_bit` |
| tx_bit | output | 1 | Bit presented to the master (1 = line released) |
| copy_busy | output | 1 | Copy in progress |

## Verification
The bench builds the block with `PAGES` = 8, a 256-byte memory. This puts the last address, FFh, where a short read crosses it, so the all-ones tail of R9 can be seen. It uses `COPY_CYCLES` = 40, so each copy finishes in a few dozen cycles. That leaves room to inject a line reset in the middle of a copy and then see the zero stream that follows. Buffer overflow, the partial-byte encoding and authorization mismatch are covered in the same short run.

// File: rtl/scm_pkg.sv
package scm_pkg;
    localparam int SP_BYTES = 32;
    localparam int SP_AW    = 5;

    localparam logic [7:0] CMD_WRSP  = 8'h0F;
    localparam logic [7:0] CMD_RDSP  = 8'hAA;
    localparam logic [7:0] CMD_CPSP  = 8'h55;
    localparam logic [7:0] CMD_RDMEM = 8'hF0;

    typedef enum logic [3:0] {
        S_CMD, S_ADDR1, S_ADDR2, S_WRD, S_RDSP,
        S_AUTH, S_COPY, S_DONE, S_ONES, S_RDMEM
    } st_e;

    typedef struct packed {
        logic             aa;
        logic             ovf;
        logic             part;
        logic [SP_AW-1:0] eoff;
    } stat_t;

    function automatic logic [7:0] put_bit(logic [7:0] base, logic [2:0] pos, logic b);
        logic [7:0] r;
        r      = base;
        r[pos] = b;
        return r;
    endfunction
endpackage

// File: rtl/sp_store.sv
module sp_store #(
    parameter int BYTES = 32,
    localparam int AW = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [BYTES];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/main_mem.sv
module main_mem #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    q
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        q <= mem[raddr];
    end
endmodule

// File: rtl/scratch_mem_ctrl.sv
module scratch_mem_ctrl
    import scm_pkg::*;
#(
    parameter int PAGES       = 64,
    parameter int COPY_CYCLES = 7500
) (
    input  logic clk,
    input  logic rst,
    input  logic line_reset,
    input  logic slot_wr,
    input  logic slot_data,
    input  logic slot_rd,
    output logic tx_bit,
    output logic copy_busy
);
    localparam int MEM_BYTES = PAGES * SP_BYTES;
    localparam int AW        = $clog2(MEM_BYTES);
    localparam int COPY_LAST = ((COPY_CYCLES > SP_BYTES) ? COPY_CYCLES : SP_BYTES + 1) - 1;
    localparam int CW        = $clog2(COPY_LAST + 1);

    st_e              st;
    logic [7:0]       cmd_q;
    logic [15:0]      ta;
    stat_t            es;
    logic [7:0]       rx_sh;
    logic [2:0]       rx_cnt;
    logic [SP_AW-1:0] wr_off;
    logic             sp_full;
    logic [2:0]       tx_idx;
    logic [1:0]       pre_cnt;
    logic [SP_AW:0]   sp_ptr;
    logic [16:0]      rd_addr;
    logic [1:0]       auth_cnt;
    logic [SP_AW-1:0] cp_off;
    logic             cp_wr_done;
    logic [CW-1:0]    cyc_cnt;

    // receive path: bits assembled at their own positions
    logic [7:0] asm_next, rx_byte, auth_exp, tx_byte, sp_rdata, mem_q;
    logic       byte_done, sp_we, mem_we, cp_in_range, rd_in_range;
    logic [15:0] cp_tgt;

    assign asm_next  = put_bit((rx_cnt == 3'd0) ? 8'h00 : rx_sh, rx_cnt, slot_data);
    assign rx_byte   = asm_next;
    assign byte_done = slot_wr && (rx_cnt == 3'd7);

    assign cp_tgt      = {ta[15:5], cp_off};
    assign cp_in_range = {1'b0, cp_tgt} < 17'(MEM_BYTES);
    assign rd_in_range = rd_addr < 17'(MEM_BYTES);

    assign sp_we  = (st == S_WRD) && slot_wr && !sp_full && !line_reset;
    assign mem_we = (st == S_COPY) && !cp_wr_done && cp_in_range;

    sp_store #(.BYTES(SP_BYTES)) u_sp (
        .clk   (clk),
        .we    (sp_we),
        .waddr (wr_off),
        .wdata (asm_next),
        .raddr ((st == S_COPY) ? cp_off : sp_ptr[SP_AW-1:0]),
        .rdata (sp_rdata)
    );

    main_mem #(.DEPTH(MEM_BYTES)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (cp_tgt[AW-1:0]),
        .wdata (sp_rdata),
        .raddr (rd_addr[AW-1:0]),
        .q     (mem_q)
    );

    always_comb begin
        case (auth_cnt)
            2'd0:    auth_exp = ta[7:0];
            2'd1:    auth_exp = ta[15:8];
            default: auth_exp = es;
        endcase
    end

    always_comb begin
        tx_byte = 8'hFF;
        case (st)
            S_RDSP: case (pre_cnt)
                2'd0:    tx_byte = ta[7:0];
                2'd1:    tx_byte = ta[15:8];
                2'd2:    tx_byte = es;
                default: tx_byte = sp_ptr[SP_AW] ? 8'hFF : sp_rdata;
            endcase
            S_RDMEM: tx_byte = rd_in_range ? mem_q : 8'hFF;
            S_DONE:  tx_byte = 8'h00;
            default: tx_byte = 8'hFF;
        endcase
    end

    assign tx_bit    = tx_byte[tx_idx];
    assign copy_busy = (st == S_COPY);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_CMD; cmd_q <= '0; ta <= '0; es <= '0;
            rx_sh <= '0; rx_cnt <= '0; wr_off <= '0; sp_full <= 1'b0;
            tx_idx <= '0; pre_cnt <= '0; sp_ptr <= '0; rd_addr <= '0;
            auth_cnt <= '0; cp_off <= '0; cp_wr_done <= 1'b0; cyc_cnt <= '0;
        end else if (line_reset && st != S_COPY) begin
            st <= S_CMD; rx_cnt <= '0; tx_idx <= '0;
        end else begin
            if (slot_wr) begin
                rx_sh  <= asm_next;
                rx_cnt <= rx_cnt + 3'd1;
            end
            case (st)
                S_CMD: if (byte_done) begin
                    cmd_q <= rx_byte;
                    case (rx_byte)
                        CMD_WRSP, CMD_RDMEM: st <= S_ADDR1;
                        CMD_RDSP: begin
                            st <= S_RDSP; pre_cnt <= '0; tx_idx <= '0;
                            sp_ptr <= {1'b0, ta[SP_AW-1:0]};
                        end
                        CMD_CPSP: begin st <= S_AUTH; auth_cnt <= '0; end
                        default:  st <= S_ONES;
                    endcase
                end
                S_ADDR1: if (byte_done) begin
                    ta[7:0] <= rx_byte; st <= S_ADDR2;
                end
                S_ADDR2: if (byte_done) begin
                    ta[15:8] <= rx_byte;
                    if (cmd_q == CMD_WRSP) begin
                        es      <= '{aa: 1'b0, ovf: 1'b0, part: 1'b0, eoff: ta[SP_AW-1:0]};
                        wr_off  <= ta[SP_AW-1:0];
                        sp_full <= 1'b0;
                        st      <= S_WRD;
                    end else begin
                        rd_addr <= {1'b0, rx_byte, ta[7:0]};
                        tx_idx  <= '0;
                        st      <= S_RDMEM;
                    end
                end
                S_WRD: if (slot_wr) begin
                    if (sp_full) es.ovf <= 1'b1;
                    else begin
                        es.eoff <= wr_off;
                        es.part <= (rx_cnt != 3'd7);
                        if (rx_cnt == 3'd7) begin
                            if (wr_off == SP_AW'(SP_BYTES - 1)) sp_full <= 1'b1;
                            else wr_off <= wr_off + 1'b1;
                        end
                    end
                end
                S_RDSP: if (slot_rd) begin
                    tx_idx <= tx_idx + 3'd1;
                    if (tx_idx == 3'd7) begin
                        if (pre_cnt != 2'd3) pre_cnt <= pre_cnt + 2'd1;
                        else if (!sp_ptr[SP_AW]) sp_ptr <= sp_ptr + 1'b1;
                    end
                end
                S_AUTH: if (byte_done) begin
                    if (rx_byte != auth_exp) st <= S_ONES;
                    else if (auth_cnt == 2'd2) begin
                        es.aa <= 1'b1; st <= S_COPY;
                        cp_off <= ta[SP_AW-1:0]; cp_wr_done <= 1'b0; cyc_cnt <= '0;
                    end else auth_cnt <= auth_cnt + 2'd1;
                end
                S_COPY: begin
                    cyc_cnt <= cyc_cnt + 1'b1;
                    if (!cp_wr_done) begin
                        if (cp_off == es.eoff) cp_wr_done <= 1'b1;
                        else cp_off <= cp_off + 1'b1;
                    end
                    if (cyc_cnt == CW'(COPY_LAST)) begin
                        st <= S_DONE; tx_idx <= '0;
                    end
                end
                S_RDMEM: if (slot_rd) begin
                    tx_idx <= tx_idx + 3'd1;
                    if (tx_idx == 3'd7 && rd_in_range) rd_addr <= rd_addr + 17'd1;
                end
                default: ;
            endcase
        end
    end

    // R3: overflow only rises once the buffer is full
    p_of_needs_full_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(es.ovf) |-> $past(sp_full));
    // R6: authorization only granted at the end of the echo phase
    p_aa_from_auth_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(es.aa) |-> $past(st) == S_AUTH);
    p_zero_after_copy_r6: assert property (@(posedge clk) disable iff (rst)
        st == S_DONE |-> !tx_bit);
    // R7: mismatch leaves the line released
    p_ones_on_mismatch_r7: assert property (@(posedge clk) disable iff (rst)
        st == S_ONES |-> tx_bit);
    // R8: bus reset cannot cut a copy short
    p_reset_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (copy_busy && line_reset && cyc_cnt != CW'(COPY_LAST)) |=> copy_busy);
    // R9: memory reads leave the status byte alone
    p_es_kept_r9: assert property (@(posedge clk) disable iff (rst)
        st == S_RDMEM |=> $stable(es));
    // R10: authorization cleared only when a write takes its address
    p_aa_clear_by_write_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(es.aa) |-> $past(st) == S_ADDR2);
endmodule

// File: tb/scratch_mem_ctrl_tb.sv
module scratch_mem_ctrl_tb;
    logic clk = 1'b0;
    logic rst, line_reset, slot_wr, slot_data, slot_rd;
    logic tx_bit, copy_busy;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    scratch_mem_ctrl #(.PAGES(8), .COPY_CYCLES(40)) u_dut (
        .clk(clk), .rst(rst), .line_reset(line_reset), .slot_wr(slot_wr),
        .slot_data(slot_data), .slot_rd(slot_rd), .tx_bit(tx_bit), .copy_busy(copy_busy)
    );

    // entry: {req, op, nbits, data}; op 1 line reset, 2 send, 3 receive+check, 4 send n bits, 5 wait copy
    localparam logic [19:0] TBL_A [50] = '{
        20'h2_1_0_00, 20'h2_2_0_0F, 20'h2_2_0_26, 20'h2_2_0_00, 20'h2_2_0_A1, 20'h2_2_0_B2, // R2
        20'h5_1_0_00, 20'h5_2_0_AA, 20'h5_3_0_26, 20'h5_3_0_00, 20'h2_3_0_07,               // R5, R2
        20'h5_3_0_A1, 20'h5_3_0_B2,
        20'h6_1_0_00, 20'h6_2_0_55, 20'h6_2_0_26, 20'h6_2_0_00, 20'h6_2_0_07, 20'h6_5_0_00, // R6
        20'h6_3_0_00,
        20'h9_1_0_00, 20'h9_2_0_F0, 20'h9_2_0_26, 20'h9_2_0_00, 20'h9_3_0_A1, 20'h9_3_0_B2, // R9
        20'hA_1_0_00, 20'hA_2_0_AA, 20'hA_3_0_26, 20'hA_3_0_00, 20'hA_3_0_87,               // R10
        20'h3_1_0_00, 20'h3_2_0_0F, 20'h3_2_0_3C, 20'h3_2_0_01, 20'h3_2_0_11, 20'h3_2_0_22, // R3
        20'h3_2_0_33, 20'h3_2_0_44, 20'h3_4_1_01,
        20'h3_1_0_00, 20'h3_2_0_AA, 20'h5_3_0_3C, 20'h5_3_0_01, 20'h3_3_0_5F, 20'h5_3_0_11,
        20'h5_3_0_22, 20'h5_3_0_33, 20'h5_3_0_44, 20'h5_3_0_FF
    };

    localparam logic [19:0] TBL_B [48] = '{
        20'h4_1_0_00, 20'h4_2_0_0F, 20'h4_2_0_E0, 20'h4_2_0_00, 20'h4_2_0_5A, 20'h4_4_3_05, // R4
        20'h4_1_0_00, 20'h4_2_0_AA, 20'h4_3_0_E0, 20'h4_3_0_00, 20'h4_3_0_21, 20'h4_3_0_5A,
        20'h4_3_0_05,
        20'h6_1_0_00, 20'h6_2_0_55, 20'h6_2_0_E0, 20'h6_2_0_00, 20'h6_2_0_21, 20'h6_5_0_00, // R6
        20'h6_3_0_00,
        20'h6_1_0_00, 20'h6_2_0_F0, 20'h6_2_0_E0, 20'h6_2_0_00, 20'h6_3_0_5A, 20'h6_3_0_05,
        20'h7_1_0_00, 20'h7_2_0_0F, 20'h7_2_0_26, 20'h7_2_0_00, 20'h7_2_0_99,               // R7
        20'h7_1_0_00, 20'h7_2_0_55, 20'h7_2_0_26, 20'h7_2_0_00, 20'h7_2_0_00, 20'h7_3_0_FF,
        20'h7_1_0_00, 20'h7_2_0_AA, 20'h7_3_0_26, 20'h7_3_0_00, 20'h7_3_0_06, 20'h7_3_0_99,
        20'h7_1_0_00, 20'h7_2_0_F0, 20'h7_2_0_26, 20'h7_2_0_00, 20'h7_3_0_A1
    };

    task automatic check(input bit ok, input int req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wbit(input logic b);
        @(negedge clk); slot_wr = 1'b1; slot_data = b;
        @(negedge clk); slot_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wbits(input logic [7:0] d, input int n);
        for (int i = 0; i < n; i++) wbit(d[i]);
    endtask

    task automatic rbyte(output logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); d[i] = tx_bit; slot_rd = 1'b1;
            @(negedge clk); slot_rd = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic lreset();
        @(negedge clk); line_reset = 1'b1;
        @(negedge clk); line_reset = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_copy();
        for (int i = 0; i < 1000 && copy_busy; i++) @(negedge clk);
    endtask

    task automatic run(input logic [19:0] e);
        logic [7:0] got;
        case (e[15:12])
            4'd1: lreset();
            4'd2: wbits(e[7:0], 8);
            4'd3: begin rbyte(got); check(got == e[7:0], int'(e[19:16]), got, e[7:0]); end
            4'd4: wbits(e[7:0], int'(e[11:8]));
            4'd5: wait_copy();
            default: ;
        endcase
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        rst = 1'b1; line_reset = 1'b0; slot_wr = 1'b0; slot_data = 1'b0; slot_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check(tx_bit == 1'b1, 11, tx_bit, 1);
        check(copy_busy == 1'b0, 11, copy_busy, 0);
        lreset(); wbits(8'hAA, 8);
        for (int i = 0; i < 3; i++) begin
            rbyte(got); check(got == 8'h00, 11, got, 0);
        end

        foreach (TBL_A[i]) run(TBL_A[i]);
        foreach (TBL_B[i]) run(TBL_B[i]);

        // R8 and R9: copy to the last page, reset during copy, read across the end
        lreset(); wbits(8'h0F, 8); wbits(8'hFE, 8); wbits(8'h00, 8);
        wbits(8'hC3, 8); wbits(8'h3C, 8);
        lreset(); wbits(8'h55, 8); wbits(8'hFE, 8); wbits(8'h00, 8); wbits(8'h1F, 8);
        @(negedge clk);
        check(copy_busy == 1'b1, 6, copy_busy, 1);
        lreset();
        check(copy_busy == 1'b1, 8, copy_busy, 1);
        wait_copy();
        rbyte(got); check(got == 8'h00, 8, got, 0);
        lreset(); wbits(8'hF0, 8); wbits(8'hFE, 8); wbits(8'h00, 8);
        rbyte(got); check(got == 8'hC3, 9, got, 8'hC3);
        rbyte(got); check(got == 8'h3C, 9, got, 8'h3C);
        rbyte(got); check(got == 8'hFF, 9, got, 8'hFF);
        rbyte(got); check(got == 8'hFF, 9, got, 8'hFF);

        // R1: unknown code, later bytes are not commands
        lreset(); wbits(8'h12, 8); wbits(8'hAA, 8);
        rbyte(got); check(got == 8'hFF, 1, got, 8'hFF);
        lreset(); wbits(8'hAA, 8);
        rbyte(got); check(got == 8'hFE, 1, got, 8'hFE);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule